// File: doc/BRIEF.md
# Triggered Buffer-Active Timer

This block opens a timed "buffer active" window, either from an external trigger that arrives on a shared pin or from a one-cycle software start. The trigger is asynchronous. It is brought into the clock domain through a flop synchronizer, and a rising-edge detector then opens the window a fixed few cycles after the edge. While the synchronized trigger stays high the window stays open. Once the trigger is released, the window stays open for the synchronizer delay plus a programmable count taken from an 8-bit timeout input. The register that holds this value resets to 25 elsewhere in the chip.

The window is given out in two forms. One is an internal active-high flag for the analog buffer control. The other is a pin-level copy whose polarity a configuration bit selects. A separate enable input gates the trigger. The software start works whatever the enable is set to.

Top module: `bufwin_timer`

## Requirements
- R1: With the block idle and trig_en = 1, if trig_in is first sampled high at rising edge e after a low sample, buf_active stays 0 after edges e and e+1 and becomes 1 after edge e+2.
- R2: While the synchronized trigger is high, buf_active stays 1, however long trig_in is held.
- R3: If trig_in is first sampled low at edge k after a high sample, and no new start occurs, buf_active stays 1 through edge k+1+T and returns to 0 after edge k+2+T. T is the value on timeout (0 to 255) while the trigger is held. With T = 25, the window closes 27 edges after the first low sample.
- R4: A new trigger rising edge while the window is still counting down reloads the count. buf_active stays 1 in every cycle with no low cycle in between, and R3 then applies to the later release.
- R5: buf_pin equals buf_active when pin_pol = 1, and equals the inverse of buf_active when pin_pol = 0. This holds in every cycle, including while the block is idle.
- R6: While trig_en = 0, trig_in has no effect. The window does not open, however long trig_in is held. Raising trig_en again while trig_in is low does not open it either.
- R7: A one-cycle sw_start sampled at edge j, with trig_in low, sets buf_active after edge j, holds it through edge j+T, and clears it after edge j+T+1.
- R8: While rst_n = 0 (active-low, asynchronous), buf_active is 0 and the count is cleared. The window opens only on a trigger edge or sw_start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous trigger from the shared pin |
| trig_en | input | 1 | 1 = trigger accepted, 0 = trigger ignored |
| sw_start | input | 1 | One-cycle software start of a window |
| timeout | input | 8 | Post-release extension count T |
| pin_pol | input | 1 | 1 = pin active-high, 0 = pin active-low |
| buf_active | output | 1 | Internal window flag, active high |
| buf_pin | output | 1 | Window flag at the selected pin polarity |

## Verification
The bench samples the exact edge on which the window opens, so a design with one synchronizer stage too few or too many opens a cycle early or late and is reported. It checks the last high cycle and the first low cycle of each extension, with T = 0, T = 25 and T = 255. An off-by-one in the count or a countdown that starts before the synchronized release shows up as a window one cycle too long or too short. A retrigger during the countdown is checked cycle by cycle, which catches a design that lets the flag drop for one cycle before restarting. A trigger held with the enable off, then the enable turned back on while the trigger is low, catches a design that ignores the gate or counts enable as an edge.

// File: rtl/bufwin_pkg.sv
package bufwin_pkg;

  // Pin level for a given window state and polarity selection.
  function automatic logic pin_level(input logic active, input logic pol);
    return pol ? active : ~active;
  endfunction

  // One-cycle pulse on a low-to-high transition of a level.
  function automatic logic is_rise(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

  // Countdown step: saturates at zero.
  function automatic logic [7:0] count_step(input logic [7:0] c);
    return (c == 8'd0) ? 8'd0 : c - 8'd1;
  endfunction

endpackage

// File: rtl/bufwin_sync.sv
module bufwin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bufwin_edge.sv
module bufwin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic en,
  output logic lvl_q,
  output logic rise
);
  import bufwin_pkg::*;

  logic prev_q;

  assign lvl_q = lvl & en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_q;

  assign rise = is_rise(lvl_q, prev_q);
endmodule

// File: rtl/bufwin_core.sv
module bufwin_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hold,
  input  logic [CNT_W-1:0] timeout,
  output logic             active,
  output logic [CNT_W-1:0] cnt
);
  import bufwin_pkg::*;

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic             expired;

  assign expired = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= timeout;
    end else if (active_q) begin
      if (hold) begin
        cnt_q <= timeout;
      end else if (expired) begin
        active_q <= 1'b0;
      end else begin
        cnt_q <= CNT_W'(count_step(8'(cnt_q)));
      end
    end
  end

  assign active = active_q;
  assign cnt    = cnt_q;
endmodule

// File: rtl/bufwin_timer.sv
module bufwin_timer #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             trig_en,
  input  logic             sw_start,
  input  logic [CNT_W-1:0] timeout,
  input  logic             pin_pol,
  output logic             buf_active,
  output logic             buf_pin
);
  import bufwin_pkg::*;

  // Named internal events, used by the bound checker.
  logic             trig_s;
  logic             trig_q;
  logic             rise_w;
  logic             start_w;
  logic [CNT_W-1:0] cnt_w;

  bufwin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(trig_in), .q(trig_s)
  );

  bufwin_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(trig_s), .en(trig_en),
    .lvl_q(trig_q), .rise(rise_w)
  );

  assign start_w = rise_w | sw_start;

  bufwin_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start_w), .hold(trig_q),
    .timeout(timeout), .active(buf_active), .cnt(cnt_w)
  );

  assign buf_pin = pin_level(buf_active, pin_pol);
endmodule

// File: rtl/bufwin_chk.sv
module bufwin_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_en,
  input logic             sw_start,
  input logic [CNT_W-1:0] timeout,
  input logic             pin_pol,
  input logic             buf_active,
  input logic             buf_pin,
  input logic             trig_q,
  input logic             rise_w,
  input logic [CNT_W-1:0] cnt_w
);
  // R1: an accepted trigger edge opens the window with a full count
  p_edge_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_w |=> (buf_active && cnt_w == $past(timeout)));

  // R2: a held synchronized trigger keeps the window open
  p_hold_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_active && trig_q) |=> buf_active);

  // R3: the window closes only from an empty count with the trigger released
  p_close_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_active) |-> ($past(cnt_w) == '0 && !$past(trig_q)));

  // R4: holding or re-triggering during a window reloads the count
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_active && trig_q && !sw_start) |=> (cnt_w == $past(timeout)));

  // R5: pin follows the selected polarity
  p_pin_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pol |-> (buf_pin == buf_active));
  p_pin_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_pol |-> (buf_pin != buf_active));

  // R6: no trigger edge is seen while the gate is off
  p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_en |-> !rise_w);

  // R7: software start opens the window on the next edge
  p_sw_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_start |=> buf_active);

  // R8: an idle block stays idle without a start event
  p_idle_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_active && !rise_w && !sw_start) |=> !buf_active);
endmodule

bind bufwin_timer bufwin_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .sw_start(sw_start),
  .timeout(timeout), .pin_pol(pin_pol), .buf_active(buf_active),
  .buf_pin(buf_pin), .trig_q(trig_q), .rise_w(rise_w), .cnt_w(cnt_w)
);

// File: tb/sim_bufwin_timer.sv
`timescale 1ns/1ps
module sim_bufwin_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_in = 1'b0;
  logic       trig_en = 1'b1;
  logic       sw_start = 1'b0;
  logic [7:0] timeout = 8'd25;
  logic       pin_pol = 1'b1;
  logic       buf_active;
  logic       buf_pin;

  int  cyc = 0;
  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  typedef struct {
    int    cyc;
    bit    act;
    bit    pin;
    string tag;
  } exp_t;

  exp_t sbq[$];
  exp_t it;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bufwin_timer u0 (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_en(trig_en),
    .sw_start(sw_start), .timeout(timeout), .pin_pol(pin_pol),
    .buf_active(buf_active), .buf_pin(buf_pin)
  );

  task automatic compare(input string tag, input bit a_act, input bit a_pin,
                         input bit e_act, input bit e_pin);
    checks++;
    if (a_act !== e_act || a_pin !== e_pin) begin
      failures++;
      $display("FAIL %s cyc=%0d active=%b pin=%b expected active=%b pin=%b",
               tag, cyc, a_act, a_pin, e_act, e_pin);
    end
  endtask

  // Monitor: pops expectations as their cycle arrives.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      it = sbq.pop_front();
      if (it.cyc == cyc) compare(it.tag, buf_active, buf_pin, it.act, it.pin);
      else begin
        checks++;
        failures++;
        $display("FAIL %s expectation for cyc=%0d missed (now %0d)", it.tag, it.cyc, cyc);
      end
    end
  end

  // Driver helpers
  task automatic push(input int c, input bit a, input string tag);
    exp_t e;
    e.cyc = c;
    e.act = a;
    e.pin = pin_pol ? a : !a;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    wait (sbq.size() == 0);
    step(2);
  endtask

  initial begin
    int n, m, r, s, t;
    // R8: reset state, pin at active-high polarity
    step(2);
    @(negedge clk);
    compare("R8", buf_active, buf_pin, 1'b0, 1'b0);
    step(1);
    rst_n = 1'b1;
    step(3);
    push(cyc + 1, 1'b0, "R8");
    drain();

    // R1, R2, R3 with timeout 25 (reset value of the timeout setting)
    t = 25; timeout = 8'(t); pin_pol = 1'b1;
    n = cyc; trig_in = 1'b1;
    push(n + 1, 1'b0, "R1");
    push(n + 2, 1'b0, "R1");
    push(n + 3, 1'b1, "R1");
    step(20);
    m = cyc;
    push(m, 1'b1, "R2");
    trig_in = 1'b0;
    // first low sample at m+1, so the window closes after edge m+3+T
    push(m + 2 + t, 1'b1, "R3");
    push(m + 3 + t, 1'b0, "R3");
    drain();

    // R3, R5: T = 0, one-cycle pulse, active-low pin
    t = 0; timeout = 8'(t); pin_pol = 1'b0;
    n = cyc; trig_in = 1'b1;
    push(n + 2, 1'b0, "R5");
    push(n + 3, 1'b1, "R5");
    push(n + 4, 1'b0, "R3");
    step(1);
    trig_in = 1'b0;
    drain();

    // R4: retrigger during the countdown keeps the window unbroken
    t = 10; timeout = 8'(t); pin_pol = 1'b1;
    n = cyc; trig_in = 1'b1;
    push(n + 3, 1'b1, "R1");
    step(5);
    m = cyc; trig_in = 1'b0;
    r = m + 15;
    for (int c = m + 1; c <= r + 2 + t; c++) push(c, 1'b1, "R4");
    push(r + 3 + t, 1'b0, "R3");
    step(5);
    trig_in = 1'b1;
    step(10);
    trig_in = 1'b0;
    drain();

    // R6: trigger ignored while the gate is off, and on re-enable while low
    t = 3; timeout = 8'(t);
    trig_en = 1'b0;
    n = cyc; trig_in = 1'b1;
    for (int c = n + 1; c <= n + 15; c++) push(c, 1'b0, "R6");
    step(10);
    trig_in = 1'b0;
    step(6);
    trig_en = 1'b1;
    n = cyc;
    for (int c = n + 1; c <= n + 6; c++) push(c, 1'b0, "R6");
    drain();

    // R7: software start with T = 4
    t = 4; timeout = 8'(t);
    s = cyc; sw_start = 1'b1;
    push(s, 1'b0, "R7");
    for (int c = s + 1; c <= s + 1 + t; c++) push(c, 1'b1, "R7");
    push(s + 2 + t, 1'b0, "R7");
    step(1);
    sw_start = 1'b0;
    drain();

    // R3: maximum count 255, one-cycle pulse
    t = 255; timeout = 8'(t);
    n = cyc; trig_in = 1'b1;
    push(n + 3, 1'b1, "R1");
    push(n + 3 + t, 1'b1, "R3");
    push(n + 4 + t, 1'b0, "R3");
    step(1);
    trig_in = 1'b0;
    drain();

    // R5: idle with active-low pin drives the pin high
    pin_pol = 1'b0;
    push(cyc + 1, 1'b0, "R5");
    drain();

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule